// File: doc/BRIEF.md
# Prescaled Sigma-Delta Pulse-Density Generator

This block turns a signed 8-bit level into a one-bit stream whose fraction of ones follows that level. A first-order accumulator runs only when a programmable clock divider fires. On each such update, the level plus 128 is added into an 8-bit accumulator, and the carry out of that addition becomes the output bit. A level of -128 therefore never produces a one. A level of +127 produces 255 ones in every 256 updates.

A single configuration word holds three fields: the run bit, the divider value and the level. Software writes the whole word in one cycle. The one-bit result leaves the block directly. It also feeds a per-pin selector. Each pin selector picks either the modulator bit or that pin's ordinary data bit, so any number of pins can share the one modulator.

Top module: `sdm_pdm_gen`

## Requirements
- R1: After reset, `pdm_o` is 0 and every pin whose select bit is 1 drives 0, while unselected pins drive their data bit.
- R2: In the configuration word, bit 16 is the run bit, bits [15:8] are the divider value P and bits [7:0] are the level as a two's-complement byte; bits [31:17] are ignored, and with bit 16 at 0 the output stays 0 whatever the other fields hold.
- R3: While running, an update occurs once every P+1 clocks, and `pdm_o` changes only on an update. The first update lands P+1 clocks after the edge that writes the run bit. If P is lowered below the clocks already counted, the next clock is an update.
- R4: On the k-th update after a start from a cleared accumulator with level t and u = t+128, `pdm_o` becomes floor(k*u/256) - floor((k-1)*u/256). This value is registered on the update's clock edge.
- R5: Over 256 updates from a cleared accumulator, the number of ones equals t+128: none for -128 and 255 for +127.
- R6: While the run bit is 0, the accumulator and `pdm_o` are held at 0. A later restart therefore follows R4 from k=1.
- R7: A level written while running is used from the next update on, and the accumulator is not cleared. An update that falls on the writing edge still uses the old level.
- R8: For every pin i, `pin_o[i]` equals `pdm_o` when `pin_sel_i[i]` is 1 and `pin_data_i[i]` otherwise, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load the configuration word this cycle |
| cfg_wdata_i | input | 32 | Configuration word (run bit, divider, level) |
| pin_sel_i | input | 4 | Per-pin source select, 1 = modulator bit |
| pin_data_i | input | 4 | Per-pin ordinary output data |
| pdm_o | output | 1 | Modulator pulse-density bit |
| pin_o | output | 4 | Per-pin output after source selection |

## Verification
A wrong accumulator value shows at `pdm_o` on the very next update as a carry that breaks the floor-difference pattern. Across 256 updates it also shows as a ones count that differs from t+128. A divider counter that is off by one moves the first output change away from the P+1 grid within the first update period. A counter that wraps after the divider is lowered delays the second update by hundreds of clocks. An accumulator that is not cleared when the block stops, or that is cleared by a write to the level, shows within a few updates as a carry that appears early or is missing.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
   // Default field layout of the configuration word
   localparam int SDM_REG_W   = 32;
   localparam int SDM_TGT_W   = 8;
   localparam int SDM_DIV_W   = 8;
   localparam int SDM_TGT_LSB = 0;
   localparam int SDM_DIV_LSB = 8;
   localparam int SDM_RUN_POS = 16;
   localparam int SDM_PINS    = 4;

   // Pin output stage variants
   typedef enum logic {
      PIN_COMB = 1'b0,
      PIN_FLOP = 1'b1
   } sdm_pin_mode_e;
endpackage

// File: rtl/sdm_cfg_reg.sv
module sdm_cfg_reg #(
   parameter int REG_W   = sdm_pkg::SDM_REG_W,
   parameter int TGT_W   = sdm_pkg::SDM_TGT_W,
   parameter int DIV_W   = sdm_pkg::SDM_DIV_W,
   parameter int TGT_LSB = sdm_pkg::SDM_TGT_LSB,
   parameter int DIV_LSB = sdm_pkg::SDM_DIV_LSB,
   parameter int RUN_POS = sdm_pkg::SDM_RUN_POS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic             run_o,
   output logic [DIV_W-1:0] div_o,
   output logic [TGT_W-1:0] tgt_o
);
   localparam int TGT_END = TGT_LSB + TGT_W;
   localparam int DIV_END = DIV_LSB + DIV_W;

   // Elaboration-time layout checks
   if (TGT_END > REG_W || DIV_END > REG_W || RUN_POS >= REG_W) begin : g_bad_fit
      $error("sdm_cfg_reg: a field lies outside the register");
   end
   if (!(TGT_END <= DIV_LSB || DIV_END <= TGT_LSB)) begin : g_bad_overlap_td
      $error("sdm_cfg_reg: level and divider fields overlap");
   end
   if ((RUN_POS >= TGT_LSB && RUN_POS < TGT_END) ||
       (RUN_POS >= DIV_LSB && RUN_POS < DIV_END)) begin : g_bad_overlap_run
      $error("sdm_cfg_reg: run bit overlaps a field");
   end

   logic             run_q;
   logic [DIV_W-1:0] div_q;
   logic [TGT_W-1:0] tgt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         div_q <= '0;
         tgt_q <= '0;
      end else if (we_i) begin
         run_q <= wdata_i[RUN_POS];
         div_q <= wdata_i[DIV_LSB +: DIV_W];
         tgt_q <= wdata_i[TGT_LSB +: TGT_W];
      end
   end

   // Bits outside the three fields are ignored by design
   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   assign run_o = run_q;
   assign div_o = div_q;
   assign tgt_o = tgt_q;
endmodule

// File: rtl/sdm_prescaler.sv
module sdm_prescaler #(
   parameter int DIV_W = sdm_pkg::SDM_DIV_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   if (DIV_W < 1) begin : g_bad_div
      $error("sdm_prescaler: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;

   // Magnitude compare: a divider lowered below the count fires at once
   assign tick_o = run_i && (cnt_q >= div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // After an update the next one is a full period away unless the divider is 0
   AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R3
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum #(
   parameter int TGT_W = sdm_pkg::SDM_TGT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [TGT_W-1:0] tgt_i,
   output logic             pdm_o
);
   if (TGT_W < 2) begin : g_bad_tgt
      $error("sdm_accum: TGT_W must be at least 2");
   end

   localparam int SUM_W = TGT_W + 1;

   logic [TGT_W-1:0] acc_q;
   logic             pdm_q;
   logic [TGT_W-1:0] lvl_u;
   logic [SUM_W-1:0] sum;

   // Offset by half range: flip the sign bit of the two's-complement level
   assign lvl_u = {~tgt_i[TGT_W-1], tgt_i[TGT_W-2:0]};
   assign sum   = {1'b0, acc_q} + {1'b0, lvl_u};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         pdm_q <= 1'b0;
      end else if (!run_i) begin
         acc_q <= '0;
         pdm_q <= 1'b0;
      end else if (tick_i) begin
         acc_q <= sum[TGT_W-1:0];
         pdm_q <= sum[TGT_W];
      end
   end

   assign pdm_o = pdm_q;

   AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!pdm_q && acc_q == '0)); // R6
   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !tick_i) |=> $stable(pdm_q)); // R3
   AST_MIN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && lvl_u == '0) |=> !pdm_q); // R5
   AST_MAX_DENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && lvl_u == '1 && acc_q != '0) |=> pdm_q); // R5
endmodule

// File: rtl/sdm_pin_mux.sv
module sdm_pin_mux #(
   parameter int                     NUM_PINS = sdm_pkg::SDM_PINS,
   parameter sdm_pkg::sdm_pin_mode_e MODE     = sdm_pkg::PIN_COMB
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                pdm_i,
   input  logic [NUM_PINS-1:0] sel_i,
   input  logic [NUM_PINS-1:0] data_i,
   output logic [NUM_PINS-1:0] pin_o
);
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("sdm_pin_mux: NUM_PINS must be at least 1");
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic pick;
      assign pick = sel_i[i] ? pdm_i : data_i[i];

      if (MODE == sdm_pkg::PIN_FLOP) begin : g_flop
         logic pin_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pin_q <= 1'b0;
            else         pin_q <= pick;
         end
         assign pin_o[i] = pin_q;
      end else begin : g_comb
         assign pin_o[i] = pick;
      end
   end

   if (MODE != sdm_pkg::PIN_FLOP) begin : g_no_clk
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
   end
endmodule

// File: rtl/sdm_pdm_gen.sv
module sdm_pdm_gen #(
   parameter int                     REG_W    = sdm_pkg::SDM_REG_W,
   parameter int                     TGT_W    = sdm_pkg::SDM_TGT_W,
   parameter int                     DIV_W    = sdm_pkg::SDM_DIV_W,
   parameter int                     TGT_LSB  = sdm_pkg::SDM_TGT_LSB,
   parameter int                     DIV_LSB  = sdm_pkg::SDM_DIV_LSB,
   parameter int                     RUN_POS  = sdm_pkg::SDM_RUN_POS,
   parameter int                     NUM_PINS = sdm_pkg::SDM_PINS,
   parameter sdm_pkg::sdm_pin_mode_e PIN_MODE = sdm_pkg::PIN_COMB
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cfg_we_i,
   input  logic [REG_W-1:0]    cfg_wdata_i,
   input  logic [NUM_PINS-1:0] pin_sel_i,
   input  logic [NUM_PINS-1:0] pin_data_i,
   output logic                pdm_o,
   output logic [NUM_PINS-1:0] pin_o
);
   logic             run;
   logic [DIV_W-1:0] div;
   logic [TGT_W-1:0] tgt;
   logic             tick;
   logic             pdm;

   sdm_cfg_reg #(
      .REG_W  (REG_W),
      .TGT_W  (TGT_W),
      .DIV_W  (DIV_W),
      .TGT_LSB(TGT_LSB),
      .DIV_LSB(DIV_LSB),
      .RUN_POS(RUN_POS)
   ) cfg_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i),
      .wdata_i(cfg_wdata_i),
      .run_o  (run),
      .div_o  (div),
      .tgt_o  (tgt)
   );

   sdm_prescaler #(
      .DIV_W(DIV_W)
   ) div_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .div_i (div),
      .tick_o(tick)
   );

   sdm_accum #(
      .TGT_W(TGT_W)
   ) acc_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .tick_i(tick),
      .tgt_i (tgt),
      .pdm_o (pdm)
   );

   sdm_pin_mux #(
      .NUM_PINS(NUM_PINS),
      .MODE    (PIN_MODE)
   ) mux_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pdm_i (pdm),
      .sel_i (pin_sel_i),
      .data_i(pin_data_i),
      .pin_o (pin_o)
   );

   assign pdm_o = pdm;
endmodule

// File: tb/sdm_pdm_gen_tb.sv
`timescale 1ns/1ps
module sdm_pdm_gen_tb_top;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [NP-1:0] psel = '0;
   logic [NP-1:0] pdat = '0;
   logic          pdm;
   logic [NP-1:0] pins;

   always #2.5 clk = ~clk;

   sdm_pdm_gen #(.NUM_PINS(NP)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_we_i   (cfg_we),
      .cfg_wdata_i(cfg_wdata),
      .pin_sel_i  (psel),
      .pin_data_i (pdat),
      .pdm_o      (pdm),
      .pin_o      (pins)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // Behavioural model state built from the requirements
   bit  m_run = 1'b0;
   int  m_div = 0;
   int  m_u   = 128;
   int  m_cnt = 0;
   int  m_acc = 0;
   bit  m_out = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] cfg_word(input bit run, input int dv, input int t);
      logic [7:0] d8;
      logic [7:0] t8;
      d8 = 8'(dv);
      t8 = 8'(t);
      return {15'd0, run, d8, t8};
   endfunction

   function automatic int exp_carry(input int u, input int k);
      return (k * u) / 256 - ((k - 1) * u) / 256;
   endfunction

   task automatic model_edge(input bit we, input logic [31:0] wd);
      if (!m_run) begin
         m_cnt = 0; m_acc = 0; m_out = 1'b0;
      end else if (m_cnt >= m_div) begin
         int s;
         s = m_acc + m_u;
         m_out = (s >= 256);
         m_acc = s % 256;
         m_cnt = 0;
      end else begin
         m_cnt++;
      end
      if (we) begin
         m_run = wd[16];
         m_div = int'(wd[15:8]);
         m_u   = int'($signed(wd[7:0])) + 128;
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic step(input bit we, input logic [31:0] wd);
      cfg_we = we;
      cfg_wdata = wd;
      @(posedge clk);
      model_edge(we, wd);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int plist[5];
      int tlist[4];
      plist = '{1, 2, 3, 7, 13};
      tlist = '{-100, 0, 37, 127};

      // ---------------- R1: reset state
      psel = 4'b1010;
      pdat = 4'b0110;
      repeat (3) @(negedge clk);
      chk(pdm == 1'b0, "R1", "pdm in reset", int'(pdm), 0);
      chk(pins == 4'b0100, "R1", "pins in reset", int'(pins), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pdm == 1'b0, "R1", "pdm after reset", int'(pdm), 0);
      chk(pins == 4'b0100, "R1", "pins after reset", int'(pins), 4);

      // ---------------- R4/R5: exhaustive level sweep, divider 0
      for (int t = -128; t < 128; t++) begin
         int u;
         int ones;
         int bad;
         u = t + 128; ones = 0; bad = 0;
         step(1'b1, cfg_word(1'b0, 0, 0));
         step(1'b1, cfg_word(1'b1, 0, t));
         for (int k = 1; k <= 256; k++) begin
            step(1'b0, '0);
            if (pdm) ones++;
            if (int'(pdm) != exp_carry(u, k)) bad++;
         end
         chk(bad == 0, "R4", "carry sequence mismatches", bad, 0);
         chk(ones == u, "R5", "ones in 256 updates", ones, u);
         if (t == -128) chk(ones == 0, "R5", "lowest level ones", ones, 0);
         if (t == 127)  chk(ones == 255, "R5", "highest level ones", ones, 255);
      end

      // ---------------- R3/R5: divider sweep
      foreach (plist[pi]) begin
         foreach (tlist[ti]) begin
            int p;
            int u;
            int ones;
            int mis;
            int offgrid;
            bit prev;
            p = plist[pi]; u = tlist[ti] + 128;
            ones = 0; mis = 0; offgrid = 0; prev = 1'b0;
            step(1'b1, cfg_word(1'b0, 0, 0));
            step(1'b1, cfg_word(1'b1, p, tlist[ti]));
            for (int k = 1; k <= 257 * (p + 1) - 1; k++) begin
               step(1'b0, '0);
               if (pdm != m_out) mis++;
               if (pdm != prev && (k % (p + 1)) != 0) offgrid++;
               if (k >= p + 1 && pdm) ones++;
               prev = pdm;
            end
            chk(mis == 0, "R3", "divided stream mismatches", mis, 0);
            chk(offgrid == 0, "R3", "changes off the update grid", offgrid, 0);
            chk(ones == u * (p + 1), "R5", "ones with divider", ones, u * (p + 1));
         end
      end

      // ---------------- R3: lowering the divider below the count
      step(1'b1, cfg_word(1'b0, 0, 0));
      step(1'b1, cfg_word(1'b1, 200, 127));
      for (int k = 0; k < 50; k++) step(1'b0, '0);
      chk(pdm == 1'b0, "R3", "no update before period", int'(pdm), 0);
      step(1'b1, cfg_word(1'b1, 10, 127));
      for (int k = 1; k <= 11; k++) step(1'b0, '0);
      chk(pdm == 1'b0, "R3", "before second update", int'(pdm), 0);
      step(1'b0, '0);
      chk(pdm == 1'b1, "R3", "second update after lowering", int'(pdm), 1);

      // ---------------- R6: stop clears and holds at 0
      begin
         int bad;
         bad = 0;
         step(1'b1, cfg_word(1'b0, 0, 0));
         step(1'b1, cfg_word(1'b1, 0, 50));
         for (int k = 0; k < 10; k++) step(1'b0, '0);
         step(1'b1, cfg_word(1'b0, 0, 50));
         for (int j = 0; j < 20; j++) begin
            step(1'b1, cfg_word(1'b0, j, j * 9));
            if (pdm != 1'b0) bad++;
         end
         chk(bad == 0, "R6", "output while stopped", bad, 0);
         step(1'b1, cfg_word(1'b1, 0, 50));
         bad = 0;
         for (int k = 1; k <= 8; k++) begin
            step(1'b0, '0);
            if (int'(pdm) != exp_carry(178, k)) bad++;
         end
         chk(bad == 0, "R6", "restart from cleared accumulator", bad, 0);
      end

      // ---------------- R7: level change keeps the accumulator
      step(1'b1, cfg_word(1'b0, 0, 0));
      step(1'b1, cfg_word(1'b1, 0, -28));
      step(1'b0, '0);
      step(1'b0, '0);
      step(1'b0, '0);
      chk(pdm == 1'b1, "R7", "third update old level", int'(pdm), 1);
      step(1'b1, cfg_word(1'b1, 0, 72));
      chk(pdm == 1'b0, "R7", "update on writing edge uses old level", int'(pdm), 0);
      step(1'b0, '0);
      chk(pdm == 1'b1, "R7", "new level without clear", int'(pdm), 1);
      step(1'b0, '0);
      chk(pdm == 1'b1, "R7", "new level second update", int'(pdm), 1);
      step(1'b0, '0);
      chk(pdm == 1'b0, "R7", "new level third update", int'(pdm), 0);

      // ---------------- R2: field decode, ignored upper bits
      begin
         int bad;
         bad = 0;
         step(1'b1, cfg_word(1'b0, 0, 0));
         step(1'b1, 32'hFFFE_FFFF);
         for (int k = 0; k < 10; k++) begin
            step(1'b0, '0);
            if (pdm != 1'b0) bad++;
         end
         chk(bad == 0, "R2", "run bit clear keeps output 0", bad, 0);
         step(1'b1, 32'h5A5B_0000);
         step(1'b0, '0);
         chk(pdm == 1'b0, "R2", "mid level update 1", int'(pdm), 0);
         step(1'b0, '0);
         chk(pdm == 1'b1, "R2", "mid level update 2", int'(pdm), 1);
         step(1'b0, '0);
         chk(pdm == 1'b0, "R2", "mid level update 3", int'(pdm), 0);
         step(1'b0, '0);
         chk(pdm == 1'b1, "R2", "mid level update 4", int'(pdm), 1);
      end

      // ---------------- R8: pin source selection, all patterns
      step(1'b1, cfg_word(1'b0, 0, 0));
      step(1'b1, cfg_word(1'b1, 0, 0));
      for (int s = 0; s < 16; s++) begin
         for (int d = 0; d < 16; d++) begin
            logic [3:0] e;
            psel = 4'(s);
            pdat = 4'(d);
            #1;
            e = (4'(s) & {4{pdm}}) | (~4'(s) & 4'(d));
            chk(pins == e, "R8", "pin select", int'(pins), int'(e));
         end
         @(negedge clk);
         step(1'b0, '0);
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule